// File: doc/BRIEF.md
# Enable-Gated Pipeline with Valid Tracking

This block is a fixed-latency chain of data registers with a 1-bit valid flag that travels beside the data. A sample enters on `din` together with its flag on `vin`. The sample comes out on `dout` after `LATENCY` enabled clock edges, and `vout` tells whether that word was a real sample. The input word is masked by `vin` before the first register, so an invalid sample travels down the chain as zero. One stage, chosen by a parameter, adds a constant. This stands in for the arithmetic that a real datapath would place there.

Two enables control the chain. `sys_ce` is a system-wide clock enable and `usr_en` is a local enable. The registers advance only when both are high and otherwise hold every bit. `usr_rst` is a synchronous clear. It is sampled only on edges where `sys_ce` is high, and it overrides `usr_en`. A small control decoder reduces the three control inputs to one action per edge. The action is named `ACT_HOLD`, `ACT_SHIFT` or `ACT_CLEAR`, and every data and valid register obeys it. The control moves as follows:

- any edge with `sys_ce` low is `ACT_HOLD`;
- `sys_ce` high with `usr_rst` high is `ACT_CLEAR`, whatever `usr_en` is;
- `sys_ce` high, `usr_rst` low and `usr_en` high is `ACT_SHIFT`;
- `sys_ce` high with both `usr_rst` and `usr_en` low is `ACT_HOLD`.

The decoder keeps no state of its own. The action chosen on one edge does not depend on earlier edges.

Top module: `gated_valid_pipe`

## Requirements
- R1: With `sys_ce` high, `usr_rst` low and `usr_en` low, an edge changes neither `dout` nor `vout`. The `din` and `vin` values applied on that edge never appear at the output.
- R2: The registers advance only when `sys_ce` AND `usr_en` are high. With `sys_ce` low, nothing changes on an edge, even when `usr_en` or `usr_rst` is high. A reset applied while `sys_ce` is low is ignored and clears nothing.
- R3: An edge with `sys_ce` and `usr_rst` both high sets every data register and every valid register to 0. After that edge, `dout` is 0 and `vout` is 0, whatever the value of `usr_en`.
- R4: When `usr_rst` and `usr_en` are both high with `sys_ce` high, the clear takes effect and no shift happens.
- R5: A sample taken on an enabled edge appears at `dout` right after the `LATENCY`-th enabled edge, counting the edge that took it. Held edges add delay but never reorder or drop samples.
- R6: `vout` comes from a 1-bit shift chain of `LATENCY` stages that advances on the same edges as the data. So `vout` is the `vin` of the sample now on `dout`.
- R7: `din` is ANDed with `vin` before the first register. An invalid sample therefore enters as 0 and leaves as `OP_OFFSET` (0 plus the constant), with `vout` 0.
- R8: After a clear, `vout` stays 0 during the first `LATENCY`-1 enabled edges, while the chain is flushing.
- R9: The stage selected by `OP_STAGE` adds `OP_OFFSET` modulo 2^`DATA_W`. A valid sample d leaves as (d + `OP_OFFSET`) mod 2^`DATA_W`, which wraps at the top of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers use its rising edge |
| sys_ce | input | 1 | System clock enable; gates both shifting and the reset |
| usr_en | input | 1 | Local enable, ANDed with `sys_ce` |
| usr_rst | input | 1 | Synchronous clear, qualified by `sys_ce`, overrides `usr_en` |
| vin | input | 1 | Valid flag for `din` |
| din | input | DATA_W | Input sample |
| vout | output | 1 | Valid flag for `dout` |
| dout | output | DATA_W | Output sample after `LATENCY` enabled edges |

## Verification
The assertions assume that the control inputs are clean Booleans, and that an edge with `sys_ce` and `usr_rst` both high comes before any other behaviour matters. Until that first clear, the register contents are undefined, and the checker ignores them. The bench holds `usr_rst` and `sys_ce` high from time zero. It changes every input on the falling edge, so each rising edge sees settled values. The bench covers each combination of the control inputs: clears with `usr_en` high and with `usr_en` low, and freezes of `sys_ce` while `usr_rst` is high. These happen while valid data fills the chain, so a missing hold or a stray clear shows up at the output.

// File: rtl/gvp_pkg.sv
package gvp_pkg;

    // Per-edge action applied to every register in the chain.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_CLEAR = 2'd2
    } act_e;

endpackage

// File: rtl/gvp_ctrl.sv
module gvp_ctrl
    import gvp_pkg::*;
(
    input  logic sys_ce,
    input  logic usr_en,
    input  logic usr_rst,
    output act_e act
);

    // Clear beats shift; nothing happens unless sys_ce is high.
    always_comb begin
        unique casez ({sys_ce, usr_rst, usr_en})
            3'b0??:  act = ACT_HOLD;
            3'b11?:  act = ACT_CLEAR;
            3'b101:  act = ACT_SHIFT;
            default: act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/gvp_stage.sv
module gvp_stage
    import gvp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter bit APPLY_OP  = 1'b0,
    parameter int OP_OFFSET = 0
) (
    input  logic              clk,
    input  act_e              act,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out
);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] d_nxt;

    generate
        if (APPLY_OP) begin : g_op
            localparam logic [DATA_W-1:0] OFS = DATA_W'(OP_OFFSET);
            assign shifted = d_in + OFS;
        end else begin : g_pass
            assign shifted = d_in;
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_CLEAR: d_nxt = '0;
            ACT_SHIFT: d_nxt = shifted;
            default:   d_nxt = d_out;
        endcase
    end

    always_ff @(posedge clk) begin
        d_out <= d_nxt;
    end

endmodule

// File: rtl/gvp_valid_pipe.sv
module gvp_valid_pipe
    import gvp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  act_e act,
    input  logic v_in,
    output logic v_out
);

    logic [DEPTH-1:0] pipe;
    logic [DEPTH-1:0] shifted;
    logic [DEPTH-1:0] pipe_nxt;

    generate
        if (DEPTH == 1) begin : g_single
            assign shifted = v_in;
        end else begin : g_multi
            assign shifted = {pipe[DEPTH-2:0], v_in};
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_CLEAR: pipe_nxt = '0;
            ACT_SHIFT: pipe_nxt = shifted;
            default:   pipe_nxt = pipe;
        endcase
    end

    always_ff @(posedge clk) begin
        pipe <= pipe_nxt;
    end

    assign v_out = pipe[DEPTH-1];

endmodule

// File: rtl/gated_valid_pipe.sv
module gated_valid_pipe
    import gvp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int LATENCY   = 4,
    parameter int OP_STAGE  = 1,
    parameter int OP_OFFSET = 3
) (
    input  logic              clk,
    input  logic              sys_ce,
    input  logic              usr_en,
    input  logic              usr_rst,
    input  logic              vin,
    input  logic [DATA_W-1:0] din,
    output logic              vout,
    output logic [DATA_W-1:0] dout
);

    // Keep the arithmetic stage inside the chain.
    localparam int OP_AT = (OP_STAGE < LATENCY) ? OP_STAGE : LATENCY - 1;

    act_e              act;
    logic [DATA_W-1:0] chain [LATENCY+1];

    gvp_ctrl u_ctrl (
        .sys_ce  (sys_ce),
        .usr_en  (usr_en),
        .usr_rst (usr_rst),
        .act     (act)
    );

    // Invalid samples enter as zero.
    assign chain[0] = din & {DATA_W{vin}};

    generate
        for (genvar s = 0; s < LATENCY; s++) begin : g_stage
            gvp_stage #(
                .DATA_W    (DATA_W),
                .APPLY_OP  (s == OP_AT),
                .OP_OFFSET (OP_OFFSET)
            ) u_stage (
                .clk   (clk),
                .act   (act),
                .d_in  (chain[s]),
                .d_out (chain[s+1])
            );
        end
    endgenerate

    gvp_valid_pipe #(
        .DEPTH (LATENCY)
    ) u_vpipe (
        .clk   (clk),
        .act   (act),
        .v_in  (vin),
        .v_out (vout)
    );

    assign dout = chain[LATENCY];

endmodule

// File: rtl/gvp_checker.sv
module gvp_checker #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 4
) (
    input logic              clk,
    input logic              sys_ce,
    input logic              usr_en,
    input logic              usr_rst,
    input logic              vout,
    input logic [DATA_W-1:0] dout
);

    localparam int CW = $clog2(LATENCY + 1);

    // Two-state: starts at 0, becomes 1 at the first accepted clear.
    bit          armed;
    bit [CW-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        armed <= armed | (usr_rst & sys_ce);
        if (usr_rst && sys_ce) begin
            fill_cnt <= '0;
        end else if (sys_ce && usr_en && (fill_cnt < CW'(LATENCY))) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    assert_hold_when_disabled_R1: assert property (
        @(posedge clk) disable iff (!armed)
        (sys_ce && !usr_en && !usr_rst) |=> ($stable(dout) && $stable(vout))
    );

    assert_freeze_without_ce_R2: assert property (
        @(posedge clk) disable iff (!armed)
        !sys_ce |=> ($stable(dout) && $stable(vout))
    );

    assert_clear_on_reset_R3: assert property (
        @(posedge clk) disable iff (!armed)
        (sys_ce && usr_rst) |=> (dout == '0 && !vout)
    );

    assert_reset_beats_enable_R4: assert property (
        @(posedge clk) disable iff (!armed)
        (sys_ce && usr_rst && usr_en) |=> !vout
    );

    assert_flush_invalid_R8: assert property (
        @(posedge clk) disable iff (!armed)
        (fill_cnt < CW'(LATENCY)) |-> !vout
    );

endmodule

bind gated_valid_pipe gvp_checker #(
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
) u_gvp_checker (
    .clk     (clk),
    .sys_ce  (sys_ce),
    .usr_en  (usr_en),
    .usr_rst (usr_rst),
    .vout    (vout),
    .dout    (dout)
);

// File: tb/tb_gated_valid_pipe.sv
`timescale 1ns/1ps
module tb_gated_valid_pipe;

    localparam int W   = 16;
    localparam int L   = 4;
    localparam int OFF = 3;

    logic         clk = 1'b0;
    logic         sys_ce = 1'b1;
    logic         usr_en = 1'b1;
    logic         usr_rst = 1'b1;
    logic         vin = 1'b0;
    logic [W-1:0] din = '0;
    logic         vout;
    logic [W-1:0] dout;

    always #4 clk = ~clk;

    gated_valid_pipe #(
        .DATA_W    (W),
        .LATENCY   (L),
        .OP_STAGE  (1),
        .OP_OFFSET (OFF)
    ) dut (
        .clk     (clk),
        .sys_ce  (sys_ce),
        .usr_en  (usr_en),
        .usr_rst (usr_rst),
        .vin     (vin),
        .din     (din),
        .vout    (vout),
        .dout    (dout)
    );

    typedef struct {
        bit           v;
        logic [W-1:0] d;
    } item_t;

    item_t        sb_q[$];
    bit           exp_v  = 1'b0;
    logic [W-1:0] exp_d  = '0;
    bit           exp_dk = 1'b0;
    bit           mon_on = 1'b0;
    bit           done   = 1'b0;
    string        tag    = "R3";
    int           checks = 0;
    int           errors = 0;

    // Driver: apply one edge's inputs, then update the scoreboard model.
    task automatic step(input bit ce, input bit en, input bit rst,
                        input bit v, input logic [W-1:0] d, input string t);
        item_t it;
        @(negedge clk);
        sys_ce  = ce;
        usr_en  = en;
        usr_rst = rst;
        vin     = v;
        din     = d;
        tag     = t;
        @(posedge clk);
        #1;
        if (ce && rst) begin
            sb_q.delete();
            exp_v  = 1'b0;
            exp_d  = '0;
            exp_dk = 1'b1;
        end else if (ce && en) begin
            it.v = v;
            it.d = (v ? d : '0) + W'(OFF);
            sb_q.push_back(it);
            if (sb_q.size() == L) begin
                exp_v  = sb_q[0].v;
                exp_d  = sb_q[0].d;
                exp_dk = 1'b1;
                void'(sb_q.pop_front());
            end else begin
                exp_v  = 1'b0;
                exp_dk = 1'b0;
            end
        end
        mon_on = 1'b1;
    endtask

    // Monitor: compare outputs away from the rising edge.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            checks++;
            if (vout !== exp_v) begin
                errors++;
                $display("FAIL %s vout actual=%0b expected=%0b", tag, vout, exp_v);
            end
            if (exp_dk) begin
                checks++;
                if (dout !== exp_d) begin
                    errors++;
                    $display("FAIL %s dout actual=%h expected=%h", tag, dout, exp_d);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R3: clear at start
        step(1, 1, 1, 0, '0, "R3");
        step(1, 1, 1, 0, '0, "R3");

        // R8: flush, then R5/R6/R9 streaming
        for (int i = 0; i < L - 1; i++) step(1, 1, 0, 1, W'(16'h0100 + i * 7), "R8");
        for (int i = 0; i < 10; i++)    step(1, 1, 0, 1, W'(16'h0200 + i * 13), "R5");

        // R7: mixed valid and invalid samples
        for (int i = 0; i < 12; i++) step(1, 1, 0, (i % 3) != 0, W'(16'hA000 + i), "R7");

        // R9: wrap at the top of the range
        step(1, 1, 0, 1, 16'hFFFE, "R9");
        step(1, 1, 0, 1, 16'hFFFF, "R9");
        for (int i = 0; i < L; i++) step(1, 1, 0, 1, W'(16'h0300 + i), "R9");

        // R1: local enable low holds
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 16'h5555, "R1");
        // R2: sys_ce low freezes, even with enable and reset high
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 16'h6666, "R2");
        for (int i = 0; i < 2; i++) step(0, 1, 1, 0, 16'h7777, "R2");
        // R6: resume, held data continues in order
        for (int i = 0; i < L + 2; i++) step(1, 1, 0, i[0], W'(16'h0400 + i), "R6");
        // R5: stalls interleaved with shifts
        for (int i = 0; i < 8; i++) step(1, i[0], 0, 1, W'(16'h0500 + i), "R5");

        // R4: reset with enable high clears
        step(1, 1, 1, 1, 16'h1234, "R4");
        for (int i = 0; i < L - 1; i++) step(1, 1, 0, 1, W'(16'h0600 + i), "R8");
        for (int i = 0; i < L + 1; i++) step(1, 1, 0, 1, W'(16'h0700 + i), "R5");

        // R3: reset with enable low also clears
        step(1, 0, 1, 1, 16'h4321, "R3");
        for (int i = 0; i < 2 * L; i++) step(1, 1, 0, 1, W'(16'h0800 + i), "R8");
        step(1, 1, 0, 0, '0, "R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule